// File: doc/BRIEF.md
# Self-Timed Successive-Approximation Sequencer

This block steps a successive-approximation conversion one bit at a time without a bit clock. A one-cycle `start` pulse opens each conversion at the sample rate. The sequencer then sets the trial code on the DAC and fires a dynamic comparator. It waits for the comparator to report a decision and keeps or drops the trial bit. It then holds the comparator in reset until both rails are back at their idle level, and only then tries the next lower bit. The sequencer runs on a fast oversampling clock. The comparator rails are asynchronous to it, so each rail passes through a two-flop synchroniser before it is used.

Completion is detected from the rails themselves. The idle level of both rails is high. A comparison has finished once either rail goes low, which is the NAND of the two rails. The bit is taken from whichever rail moved. Because each bit waits only as long as the comparator needs, a conversion takes longer when the residues are small and the comparator is slow.

If the comparator never answers within a bounded time, the bit is forced to 0 and the conversion is marked as suspect. A new `start` that arrives before the last bit is decided ends the running conversion. The bits decided so far are reported with an incomplete flag, and a fresh conversion starts.

Top module: `sar_async_seq`

## Requirements
- R1: After reset, `cmp_fire`, `cmp_reset`, `result_valid` and `result_incomplete` are 0, and `dac_code` and `result` are all zeros.
- R2: One clock after a `start` pulse is sampled while the sequencer is idle, `cmp_fire` is 1 and `dac_code` holds only its most significant bit set.
- R3: A low `cmp_p` (with `cmp_n` high) decides the bit under test as 1, and a low `cmp_n` decides it as 0. The bit is placed at the position being tested and the next lower bit is set for trial. When the comparator reports `cmp_p` low exactly when the input is at or above `dac_code`, the final `result` equals the binary-search code of the input.
- R4: `cmp_fire` and `cmp_reset` are never high together. Every fall of `cmp_fire` is met by `cmp_reset` in the same cycle. A completed conversion shows exactly N_BITS rising edges of `cmp_reset`.
- R5: `cmp_fire` is not raised again after a reset phase until both synchronised rails have returned high and at least three reset cycles have elapsed.
- R6: `result_valid` is a single-cycle pulse that comes once all N_BITS bits are decided. In that cycle, `cmp_reset` is high.
- R7: If neither rail falls within TIMEOUT clocks of firing, the bit is decided as 0 and `meta_flag` is 1 with that conversion's result. `cmp_fire` never stays high for more than TIMEOUT cycles in a row.
- R8: A `start` sampled before the final bit is decided pulses `result_incomplete` for one cycle, with `result` holding the bits decided so far and zeros below them. No `result_valid` comes in that cycle. A new conversion then runs to completion.
- R9: The conversion time grows with comparator decision delay, since no fixed bit period exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle conversion start at the sample rate |
| cmp_p | input | 1 | Comparator rail, falls low for a 1 decision (idle high) |
| cmp_n | input | 1 | Comparator rail, falls low for a 0 decision (idle high) |
| cmp_fire | output | 1 | Comparator evaluate enable |
| cmp_reset | output | 1 | Comparator reset/precharge enable |
| dac_code | output | N_BITS | Trial code driving the DAC switches |
| result | output | N_BITS | Final or partial conversion code |
| result_valid | output | 1 | One-cycle strobe for a complete result |
| result_incomplete | output | 1 | One-cycle strobe for an aborted partial result |
| meta_flag | output | 1 | A bit in this result timed out |

## Verification
The MSB trial and `cmp_fire` are due one clock after `start` is sampled, and the bench samples them at the next falling edge. A rail change is registered by the decision logic on the third rising edge after it is driven: two edges for the synchroniser and one for the decision register. For this reason the bench does not predict exact bit times. It waits at falling edges for the `result_valid` or `result_incomplete` pulse and compares `result` in that same cycle. It checks that the strobe is gone one falling edge later. For aborts, the bench counts the `cmp_fire` falls it saw before raising `start`, which tells it how many leading bits the partial result holds.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_CLEAR = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sar_rail_sync.sv
module sar_rail_sync #(
    parameter int   WIDTH     = 2,
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= {WIDTH{RESET_VAL}};
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sar_done_detect.sv
module sar_done_detect (
    input  logic rail_p,
    input  logic rail_n,
    output logic ready,
    output logic decision
);
    // either rail leaving its high idle level means the comparison is over
    assign ready    = ~(rail_p & rail_n);
    assign decision = ~rail_p;
endmodule

// File: rtl/sar_async_seq.sv
module sar_async_seq #(
    parameter int N_BITS  = 6,
    parameter int TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp_p,
    input  logic              cmp_n,
    output logic              cmp_fire,
    output logic              cmp_reset,
    output logic [N_BITS-1:0] dac_code,
    output logic [N_BITS-1:0] result,
    output logic              result_valid,
    output logic              result_incomplete,
    output logic              meta_flag
);
    import sar_seq_pkg::*;

    localparam int SYNC_STAGES = 2;
    localparam int CLEAR_MIN   = SYNC_STAGES + 1;
    localparam int IDXW        = (N_BITS > 1) ? $clog2(N_BITS) : 1;
    localparam int TW          = $clog2(TIMEOUT + CLEAR_MIN + 1);
    localparam logic [N_BITS-1:0] MSB_TRIAL = {1'b1, {(N_BITS-1){1'b0}}};

    typedef struct packed {
        seq_state_e        state;
        logic [N_BITS-1:0] code;
        logic [IDXW-1:0]   idx;
        logic [TW-1:0]     timer;
        logic              last;
        logic              meta;
        logic [N_BITS-1:0] res;
        logic              valid;
        logic              incomplete;
        logic              meta_out;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic [1:0] rails_s;
    logic       ready_s, decision_s;

    sar_rail_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmp_p, cmp_n}),
        .q     (rails_s)
    );

    sar_done_detect u_done (
        .rail_p   (rails_s[1]),
        .rail_n   (rails_s[0]),
        .ready    (ready_s),
        .decision (decision_s)
    );

    logic [N_BITS:0]   low_mask;
    logic [N_BITS-1:0] partial, trial_bit, kept_code;
    logic              bit_val, meta_new;

    always_comb begin
        r_d            = r_q;
        r_d.valid      = 1'b0;
        r_d.incomplete = 1'b0;

        low_mask  = ((N_BITS+1)'(2) << r_q.idx) - (N_BITS+1)'(1);
        partial   = r_q.code & ~low_mask[N_BITS-1:0];
        trial_bit = N_BITS'(1) << r_q.idx;
        bit_val   = ready_s & decision_s;
        meta_new  = r_q.meta | ~ready_s;
        kept_code = bit_val ? r_q.code : (r_q.code & ~trial_bit);

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_EVAL;
                    r_d.code  = MSB_TRIAL;
                    r_d.idx   = IDXW'(N_BITS-1);
                    r_d.timer = '0;
                    r_d.meta  = 1'b0;
                    r_d.last  = 1'b0;
                end
            end
            ST_EVAL: begin
                if (start) begin
                    r_d.res        = partial;
                    r_d.incomplete = 1'b1;
                    r_d.meta_out   = r_q.meta;
                    r_d.state      = ST_CLEAR;
                    r_d.code       = MSB_TRIAL;
                    r_d.idx        = IDXW'(N_BITS-1);
                    r_d.timer      = '0;
                    r_d.meta       = 1'b0;
                    r_d.last       = 1'b0;
                end else if (ready_s || (r_q.timer == TW'(TIMEOUT-1))) begin
                    r_d.state = ST_CLEAR;
                    r_d.timer = '0;
                    r_d.meta  = meta_new;
                    if (r_q.idx == '0) begin
                        r_d.code     = kept_code;
                        r_d.res      = kept_code;
                        r_d.valid    = 1'b1;
                        r_d.meta_out = meta_new;
                        r_d.last     = 1'b1;
                    end else begin
                        r_d.code = kept_code | (trial_bit >> 1);
                        r_d.idx  = r_q.idx - IDXW'(1);
                    end
                end else begin
                    r_d.timer = r_q.timer + TW'(1);
                end
            end
            ST_CLEAR: begin
                if (start) begin
                    if (!r_q.last) begin
                        r_d.res        = partial;
                        r_d.incomplete = 1'b1;
                        r_d.meta_out   = r_q.meta;
                    end
                    r_d.code  = MSB_TRIAL;
                    r_d.idx   = IDXW'(N_BITS-1);
                    r_d.timer = '0;
                    r_d.meta  = 1'b0;
                    r_d.last  = 1'b0;
                end else if ((r_q.timer >= TW'(CLEAR_MIN-1)) && !ready_s) begin
                    r_d.state = r_q.last ? ST_IDLE : ST_EVAL;
                    r_d.timer = '0;
                end else if (r_q.timer < TW'(CLEAR_MIN-1)) begin
                    r_d.timer = r_q.timer + TW'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmp_fire          = (r_q.state == ST_EVAL);
    assign cmp_reset         = (r_q.state == ST_CLEAR);
    assign dac_code          = r_q.code;
    assign result            = r_q.res;
    assign result_valid      = r_q.valid;
    assign result_incomplete = r_q.incomplete;
    assign meta_flag         = r_q.meta_out;
endmodule

// File: rtl/sar_async_seq_chk.sv
module sar_async_seq_chk #(
    parameter int TIMEOUT = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cmp_p,
    input logic cmp_n,
    input logic cmp_fire,
    input logic cmp_reset,
    input logic result_valid,
    input logic result_incomplete
);
    localparam int CW = $clog2(TIMEOUT + 2);

    logic [CW-1:0] fire_run_q;
    logic [2:0]    idle_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire_run_q <= '0;
            idle_run_q <= '0;
        end else begin
            fire_run_q <= cmp_fire ? fire_run_q + CW'(1) : '0;
            if (cmp_reset && cmp_p && cmp_n) begin
                if (idle_run_q != 3'd7) idle_run_q <= idle_run_q + 3'd1;
            end else begin
                idle_run_q <= '0;
            end
        end
    end

    AST_CTRL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_fire && cmp_reset)); // R4
    AST_FIRE_THEN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_fire) |-> cmp_reset); // R4
    AST_REFIRE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmp_fire) && $past(cmp_reset)) |-> (idle_run_q >= 3'd2)); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R6
    AST_VALID_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> cmp_reset); // R6
    AST_FIRE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fire |-> (fire_run_q < CW'(TIMEOUT))); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(result_valid && result_incomplete)); // R8
endmodule

bind sar_async_seq sar_async_seq_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmp_p             (cmp_p),
    .cmp_n             (cmp_n),
    .cmp_fire          (cmp_fire),
    .cmp_reset         (cmp_reset),
    .result_valid      (result_valid),
    .result_incomplete (result_incomplete)
);

// File: tb/sar_async_seq_bench.sv
`timescale 1ns/1ps
module sar_async_seq_bench;
    localparam int N       = 6;
    localparam int TIMEOUT = 16;
    localparam logic [N-1:0] MSB = {1'b1, {(N-1){1'b0}}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_p = 1'b1;
    logic cmp_n = 1'b1;
    logic cmp_fire, cmp_reset, result_valid, result_incomplete, meta_flag;
    logic [N-1:0] dac_code, result;

    int checks = 0;
    int errors = 0;
    int cmp_vin = 0;
    int cmp_dly = 0;
    logic [N-1:0] cmp_stuck = '0;
    int dcnt = 0;

    always #2 clk = ~clk;

    sar_async_seq #(.N_BITS(N), .TIMEOUT(TIMEOUT)) u_sar_async_seq (
        .clk (clk), .rst_n (rst_n), .start (start),
        .cmp_p (cmp_p), .cmp_n (cmp_n),
        .cmp_fire (cmp_fire), .cmp_reset (cmp_reset),
        .dac_code (dac_code), .result (result),
        .result_valid (result_valid), .result_incomplete (result_incomplete),
        .meta_flag (meta_flag)
    );

    // comparator model: rails idle high, one falls after a delay while fired
    always @(negedge clk) begin
        if (!rst_n || cmp_reset) begin
            cmp_p = 1'b1; cmp_n = 1'b1; dcnt = 0;
        end else if (cmp_fire && cmp_p && cmp_n) begin
            if (((dac_code & (~dac_code + N'(1))) & cmp_stuck) == '0) begin
                if (dcnt >= cmp_dly) begin
                    if (cmp_vin >= int'(dac_code)) cmp_p = 1'b0;
                    else cmp_n = 1'b0;
                end else begin
                    dcnt++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_code(input int vin, input logic [N-1:0] stuck);
        logic [N-1:0] code = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (!stuck[i] && vin >= int'(code | (N'(1) << i))) code = code | (N'(1) << i);
        end
        return code;
    endfunction

    function automatic logic [N-1:0] top_mask(input int k);
        if (k <= 0) return '0;
        return ~((N'(1) << (N-k)) - N'(1));
    endfunction

    task automatic wait_idle();
        int guard = 0;
        while ((cmp_reset || cmp_fire) && guard < 100) begin
            @(negedge clk); guard++;
        end
    endtask

    task automatic run_conv(input int vin, input int dly, input logic [N-1:0] stuck,
                            input bit chk_msb, output int cyc);
        int resets = 0;
        logic prev_rst;
        cmp_vin = vin; cmp_dly = dly; cmp_stuck = stuck;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (chk_msb) check(cmp_fire && dac_code == MSB, "R2 msb trial", int'(dac_code), int'(MSB));
        cyc = 1;
        prev_rst = cmp_reset;
        while (!result_valid && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (cmp_reset && !prev_rst) resets++;
            prev_rst = cmp_reset;
        end
        check(result_valid == 1'b1, "R6 valid seen", int'(result_valid), 1);
        check(result == exp_code(vin, stuck), "R3 result", int'(result), int'(exp_code(vin, stuck)));
        check(meta_flag == (stuck != '0), "R7 meta flag", int'(meta_flag), int'(stuck != '0));
        check(resets == N, "R4 reset per bit", resets, N);
        @(negedge clk);
        check(result_valid == 1'b0, "R6 single pulse", int'(result_valid), 0);
        wait_idle();
    endtask

    task automatic run_abort(input int vin, input int after, input int vin2);
        int falls = 0;
        int cyc = 0;
        logic prev_fire;
        logic [N-1:0] exp_part;
        cmp_vin = vin; cmp_dly = 6; cmp_stuck = '0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        prev_fire = cmp_fire;
        for (int i = 0; i < after; i++) begin
            @(negedge clk);
            if (prev_fire && !cmp_fire) falls++;
            prev_fire = cmp_fire;
        end
        exp_part = exp_code(vin, '0) & top_mask(falls);
        start = 1'b1; cmp_vin = vin2;
        @(negedge clk) start = 1'b0;
        check(result_incomplete == 1'b1, "R8 incomplete pulse", int'(result_incomplete), 1);
        check(result_valid == 1'b0, "R8 no valid on abort", int'(result_valid), 0);
        check(result == exp_part, "R8 partial result", int'(result), int'(exp_part));
        @(negedge clk);
        check(result_incomplete == 1'b0, "R8 incomplete single", int'(result_incomplete), 0);
        while (!result_valid && cyc < 3000) begin
            @(negedge clk); cyc++;
        end
        check(result == exp_code(vin2, '0), "R8 restart result", int'(result), int'(exp_code(vin2, '0)));
        @(negedge clk);
        wait_idle();
    endtask

    initial begin
        #(4ns * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc_fast, cyc_slow, c;
        int seed;
        seed = int'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check(!cmp_fire && !cmp_reset, "R1 ctrl idle", int'({cmp_fire, cmp_reset}), 0);
        check(!result_valid && !result_incomplete, "R1 flags idle", int'({result_valid, result_incomplete}), 0);
        check(dac_code == '0 && result == '0, "R1 codes zero", int'(dac_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_conv(0, 0, '0, 1'b1, c);
        run_conv((1 << N) - 1, 2, '0, 1'b1, c);
        run_conv(1 << (N-1), 1, '0, 1'b1, c);
        run_conv((1 << (N-1)) - 1, 3, '0, 1'b1, c);
        for (int i = 0; i < 30; i++) begin
            run_conv(int'($urandom_range((1 << N) - 1, 0)), int'($urandom_range(5, 0)), '0, 1'b1, c);
        end

        // R7 timeout on the MSB and on the LSB
        run_conv((1 << N) - 1, 1, MSB, 1'b1, c);
        run_conv(45, 1, N'(1), 1'b1, c);
        run_conv(50, 2, N'(6), 1'b1, c);

        // R9 conversion time follows comparator delay
        run_conv(37, 0, '0, 1'b0, cyc_fast);
        run_conv(37, 7, '0, 1'b0, cyc_slow);
        check(cyc_slow > cyc_fast, "R9 time grows with delay", cyc_slow, cyc_fast + 1);

        // R8 start before the final bit
        run_abort(45, 25, 20);
        run_abort(60, 3, 9);
        run_abort(33, 48, 63);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule